// File: doc/BRIEF.md
# Two-Level Debug Breakpoint Trigger Unit

This block watches a processor's instruction fetches and its local-bus operand accesses and raises a debug response when a programmed breakpoint condition is met. It has three comparators: a fetch-address match under a bit mask, an operand address that falls inside an inclusive range, and an operand data match under a bit mask. Any of them can feed the first trigger level. Any of them can also feed a second level, which is armed only after the first level has fired. The response is either a core halt request or a debug interrupt request that outranks the non-maskable interrupt. A fetch-address trigger responds in the same cycle as the fetch, so it is precise. A bus trigger is held pending until the next instruction sample point, so it is imprecise.

A sequencer with five named states tracks progress and exposes it as a 4-bit status code:
- `ST_OFF` (0000): nothing armed.
- `ST_ARM1` (0001): waiting for level 1.
- `ST_HIT1` (0010): level 1 fired in a single-level setup.
- `ST_ARM2` (0101): level 1 fired and level 2 is armed.
- `ST_HIT2` (0110): level 2 fired.

The transitions are:
- Any state moves to `ST_ARM1`, or to `ST_OFF` if no level-1 source is enabled, on a control write.
- `ST_ARM1` moves to `ST_HIT1` on a level-1 hit when no level-2 source is enabled.
- `ST_ARM1` moves to `ST_ARM2` on a level-1 hit when a level-2 source is enabled.
- `ST_ARM2` moves to `ST_HIT2` on a level-2 hit.
- `ST_HIT1` and `ST_HIT2` move to `ST_OFF` when the status register is read.

The same status, shifted left by one bit, is shown on a 4-bit debug port whenever trace data is not occupying that port.

Software programs the unit through a flat register port with eight selects:
- 0: control, 8 bits.
- 1: fetch compare value.
- 2: fetch mask.
- 3: range low bound.
- 4: range high bound.
- 5: data compare value.
- 6: data mask.
- 7: status, read-only.

The control register fields are:
- [1:0]: response mode.
- [2]: level-1 fetch enable.
- [3]: level-1 range enable.
- [4]: level-1 data enable.
- [5]: level-2 fetch enable.
- [6]: level-2 range enable.
- [7]: level-2 data enable.

Top module: `dbg_trig_unit`

## Requirements
- R1: The fetch comparator hits when `fetch_vld` is high and `fetch_pc` equals the fetch compare value in every bit whose fetch mask bit is 1; bits whose mask bit is 0 are ignored.
- R2: The range comparator hits when `bus_vld` is high and low bound <= `bus_addr` <= high bound, with both bounds included.
- R3: The data comparator hits when `bus_vld` is high and `bus_data` equals the data compare value in every bit whose data mask bit is 1.
- R4: With level-1 sources enabled and no level-2 source enabled, a level-1 hit in status 0001 moves the status to 0010 and produces a response.
- R5: With a level-2 source enabled, a level-1 hit in 0001 moves the status to 0101 without a response. A level-2 hit in 0101 then moves it to 0110 with a response. Level-2 hits while the status is 0001 have no effect.
- R6: A read of select 7 returns the status in bits [3:0] and clears it to 0000 when it is 0010 or 0110. A read in 0001 or 0101 leaves the status unchanged.
- R7: A write to the control register (select 0) sets the status to 0001 if any of bits [4:2] of the written value is 1, and to 0000 otherwise. It discards a pending bus trigger, and it takes priority over a hit or a read in the same cycle.
- R8: Response mode 01 makes a response a one-cycle `halt_req` pulse. Mode 10 makes it a one-cycle `irq_req` pulse. Modes 00 and 11 drive neither, but the status still advances.
- R9: A final trigger to which the fetch comparator contributes responds in the same cycle as the matching fetch.
- R10: A final trigger raised only by bus comparators is held pending. It responds in the first later cycle with `sample_pt` high, as a single pulse, and is then cleared.
- R11: `dbg_port` equals `trace_nib` while `trace_busy` is high. Otherwise it equals {status[2:0], 1'b0}, which gives 0000, 0010, 0100, 1010 or 1100.
- R12: After reset, every register reads zero, the status is 0000 and no response is driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (status read clears it) |
| reg_sel | input | 3 | Register select |
| reg_wdata | input | RW (32) | Write data |
| reg_rdata | output | RW (32) | Read data for `reg_sel`, combinational |
| fetch_vld | input | 1 | Instruction fetch address valid |
| fetch_pc | input | AW (32) | Instruction fetch address |
| bus_vld | input | 1 | Operand bus access valid |
| bus_addr | input | AW (32) | Operand address |
| bus_data | input | DW (32) | Operand data |
| sample_pt | input | 1 | One-cycle instruction sample point strobe |
| trace_busy | input | 1 | Debug port carries trace data this cycle |
| trace_nib | input | 4 | Trace nibble to show when busy |
| dbg_port | output | 4 | Debug data port |
| halt_req | output | 1 | Core halt request pulse |
| irq_req | output | 1 | Debug interrupt request pulse |

## Verification
The assertions assume that `sample_pt` is a single-cycle strobe and that `reg_wr` and `reg_rd` are never high together with select 0. A write with select 0 is therefore the only event that clears pending state or re-arms the sequencer. The bench drives at most one of write, read, fetch, bus access or sample strobe per cycle, always as one-cycle pulses. Sample strobes are issued both with and without a pending trigger. The two-level sequences place level-2 matches before level 1 has fired, so the ignored-hit path is exercised.

// File: rtl/dbg_trig_pkg.sv
package dbg_trig_pkg;
    typedef enum logic [2:0] {
        ST_OFF,
        ST_ARM1,
        ST_HIT1,
        ST_ARM2,
        ST_HIT2
    } seq_state_e;

    typedef enum logic [1:0] {
        RSP_QUIET_A = 2'b00,
        RSP_HALT    = 2'b01,
        RSP_IRQ     = 2'b10,
        RSP_QUIET_B = 2'b11
    } rsp_mode_e;

    localparam int SRC_N     = 3;   // fetch, range, data
    localparam int SRC_FETCH = 0;
    localparam int SRC_RANGE = 1;
    localparam int SRC_DATA  = 2;
    localparam int SEL_W     = 3;
    localparam int CTL_W     = 2 + 2 * SRC_N;

    localparam logic [SEL_W-1:0] SEL_CTL  = 3'd0;
    localparam logic [SEL_W-1:0] SEL_PCV  = 3'd1;
    localparam logic [SEL_W-1:0] SEL_PCM  = 3'd2;
    localparam logic [SEL_W-1:0] SEL_LO   = 3'd3;
    localparam logic [SEL_W-1:0] SEL_HI   = 3'd4;
    localparam logic [SEL_W-1:0] SEL_DV   = 3'd5;
    localparam logic [SEL_W-1:0] SEL_DM   = 3'd6;
    localparam logic [SEL_W-1:0] SEL_STAT = 3'd7;
endpackage

// File: rtl/dbg_trig_cmp.sv
module dbg_trig_cmp
    import dbg_trig_pkg::*;
#(
    parameter int AW = 32,
    parameter int DW = 32
) (
    input  logic             fetch_vld,
    input  logic [AW-1:0]    fetch_pc,
    input  logic             bus_vld,
    input  logic [AW-1:0]    bus_addr,
    input  logic [DW-1:0]    bus_data,
    input  logic [AW-1:0]    pc_val,
    input  logic [AW-1:0]    pc_msk,
    input  logic [AW-1:0]    rng_lo,
    input  logic [AW-1:0]    rng_hi,
    input  logic [DW-1:0]    dat_val,
    input  logic [DW-1:0]    dat_msk,
    output logic [SRC_N-1:0] hit
);
    always_comb begin
        hit            = '0;
        hit[SRC_FETCH] = fetch_vld && (((fetch_pc ^ pc_val) & pc_msk) == '0);
        hit[SRC_RANGE] = bus_vld && (bus_addr >= rng_lo) && (bus_addr <= rng_hi);
        hit[SRC_DATA]  = bus_vld && (((bus_data ^ dat_val) & dat_msk) == '0);
    end
endmodule

// File: rtl/dbg_trig_seq.sv
module dbg_trig_seq
    import dbg_trig_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ctl_wr,
    input  logic       new_l1_any,
    input  logic       l1_fetch,
    input  logic       l1_bus,
    input  logic       l2_fetch,
    input  logic       l2_bus,
    input  logic       l2_any,
    input  logic       stat_rd,
    output logic [3:0] status,
    output logic       fire,
    output logic       fire_precise
);
    seq_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_OFF;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        if (ctl_wr) begin
            state_d = new_l1_any ? ST_ARM1 : ST_OFF;
        end else begin
            unique case (state_q)
                ST_OFF:  state_d = ST_OFF;
                ST_ARM1: if (l1_fetch || l1_bus) state_d = l2_any ? ST_ARM2 : ST_HIT1;
                ST_ARM2: if (l2_fetch || l2_bus) state_d = ST_HIT2;
                ST_HIT1: if (stat_rd) state_d = ST_OFF;
                ST_HIT2: if (stat_rd) state_d = ST_OFF;
                default: state_d = ST_OFF;
            endcase
        end
    end

    always_comb begin
        status       = 4'b0000;
        fire         = 1'b0;
        fire_precise = 1'b0;
        unique case (state_q)
            ST_OFF:  status = 4'b0000;
            ST_ARM1: begin
                status       = 4'b0001;
                fire         = !ctl_wr && !l2_any && (l1_fetch || l1_bus);
                fire_precise = fire && l1_fetch;
            end
            ST_HIT1: status = 4'b0010;
            ST_ARM2: begin
                status       = 4'b0101;
                fire         = !ctl_wr && (l2_fetch || l2_bus);
                fire_precise = fire && l2_fetch;
            end
            ST_HIT2: status = 4'b0110;
            default: status = 4'b0000;
        endcase
    end

    AST_WR_REARM: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_wr |=> status == ($past(new_l1_any) ? 4'b0001 : 4'b0000)); // R7
    AST_ARM2_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        (status == 4'b0101 && $past(status) != 4'b0101 && !$past(ctl_wr)) |-> $past(status) == 4'b0001); // R5
    AST_HIT2_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (status == 4'b0110 && !ctl_wr && !stat_rd) |=> status == 4'b0110); // R6
endmodule

// File: rtl/dbg_trig_resp.sv
module dbg_trig_resp
    import dbg_trig_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       fire,
    input  logic       fire_precise,
    input  logic       sample_pt,
    input  logic       flush,
    input  logic [1:0] mode,
    output logic       halt_req,
    output logic       irq_req
);
    logic pend_q;
    logic take;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                      pend_q <= 1'b0;
        else if (flush)                  pend_q <= 1'b0;
        else if (fire && !fire_precise)  pend_q <= 1'b1;
        else if (sample_pt)              pend_q <= 1'b0;
    end

    always_comb begin
        take     = (fire && fire_precise) || (pend_q && sample_pt);
        halt_req = take && (rsp_mode_e'(mode) == RSP_HALT);
        irq_req  = take && (rsp_mode_e'(mode) == RSP_IRQ);
    end

    AST_ONE_RESP: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({halt_req, irq_req})); // R8
    AST_PEND_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_q && sample_pt && !fire) |=> !pend_q); // R10
    AST_BUS_AT_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
        ((halt_req || irq_req) && !fire_precise) |-> sample_pt); // R10
    AST_PRECISE_NOW: assert property (@(posedge clk) disable iff (!rst_n)
        (fire_precise && mode == 2'b01) |-> halt_req); // R9
endmodule

// File: rtl/dbg_trig_unit.sv
module dbg_trig_unit
    import dbg_trig_pkg::*;
#(
    parameter int AW = 32,
    parameter int DW = 32,
    localparam int RW = (AW > DW) ? AW : DW
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic             reg_rd,
    input  logic [SEL_W-1:0] reg_sel,
    input  logic [RW-1:0]    reg_wdata,
    output logic [RW-1:0]    reg_rdata,
    input  logic             fetch_vld,
    input  logic [AW-1:0]    fetch_pc,
    input  logic             bus_vld,
    input  logic [AW-1:0]    bus_addr,
    input  logic [DW-1:0]    bus_data,
    input  logic             sample_pt,
    input  logic             trace_busy,
    input  logic [3:0]       trace_nib,
    output logic [3:0]       dbg_port,
    output logic             halt_req,
    output logic             irq_req
);
    logic [CTL_W-1:0] ctl_q;
    logic [AW-1:0]    pcv_q, pcm_q, lo_q, hi_q;
    logic [DW-1:0]    dv_q, dm_q;
    logic [SRC_N-1:0] hit, en_l1, en_l2;
    logic [3:0]       status;
    logic             ctl_wr, stat_rd, fire, fire_precise;

    assign ctl_wr  = reg_wr && (reg_sel == SEL_CTL);
    assign stat_rd = reg_rd && (reg_sel == SEL_STAT);
    assign en_l1   = ctl_q[2 +: SRC_N];
    assign en_l2   = ctl_q[2 + SRC_N +: SRC_N];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '0;
            pcv_q <= '0;
            pcm_q <= '0;
            lo_q  <= '0;
            hi_q  <= '0;
            dv_q  <= '0;
            dm_q  <= '0;
        end else if (reg_wr) begin
            unique case (reg_sel)
                SEL_CTL: ctl_q <= reg_wdata[CTL_W-1:0];
                SEL_PCV: pcv_q <= reg_wdata[AW-1:0];
                SEL_PCM: pcm_q <= reg_wdata[AW-1:0];
                SEL_LO:  lo_q  <= reg_wdata[AW-1:0];
                SEL_HI:  hi_q  <= reg_wdata[AW-1:0];
                SEL_DV:  dv_q  <= reg_wdata[DW-1:0];
                SEL_DM:  dm_q  <= reg_wdata[DW-1:0];
                default: ;
            endcase
        end
    end

    always_comb begin
        reg_rdata = '0;
        unique case (reg_sel)
            SEL_CTL:  reg_rdata[CTL_W-1:0] = ctl_q;
            SEL_PCV:  reg_rdata[AW-1:0]    = pcv_q;
            SEL_PCM:  reg_rdata[AW-1:0]    = pcm_q;
            SEL_LO:   reg_rdata[AW-1:0]    = lo_q;
            SEL_HI:   reg_rdata[AW-1:0]    = hi_q;
            SEL_DV:   reg_rdata[DW-1:0]    = dv_q;
            SEL_DM:   reg_rdata[DW-1:0]    = dm_q;
            SEL_STAT: reg_rdata[3:0]       = status;
            default:  reg_rdata = '0;
        endcase
    end

    dbg_trig_cmp #(.AW(AW), .DW(DW)) u_cmp (
        .fetch_vld(fetch_vld), .fetch_pc(fetch_pc),
        .bus_vld(bus_vld), .bus_addr(bus_addr), .bus_data(bus_data),
        .pc_val(pcv_q), .pc_msk(pcm_q), .rng_lo(lo_q), .rng_hi(hi_q),
        .dat_val(dv_q), .dat_msk(dm_q), .hit(hit)
    );

    dbg_trig_seq u_seq (
        .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr),
        .new_l1_any(|reg_wdata[2 +: SRC_N]),
        .l1_fetch(en_l1[SRC_FETCH] && hit[SRC_FETCH]),
        .l1_bus(|(en_l1[SRC_DATA:SRC_RANGE] & hit[SRC_DATA:SRC_RANGE])),
        .l2_fetch(en_l2[SRC_FETCH] && hit[SRC_FETCH]),
        .l2_bus(|(en_l2[SRC_DATA:SRC_RANGE] & hit[SRC_DATA:SRC_RANGE])),
        .l2_any(|en_l2), .stat_rd(stat_rd),
        .status(status), .fire(fire), .fire_precise(fire_precise)
    );

    dbg_trig_resp u_resp (
        .clk(clk), .rst_n(rst_n), .fire(fire), .fire_precise(fire_precise),
        .sample_pt(sample_pt), .flush(ctl_wr), .mode(ctl_q[1:0]),
        .halt_req(halt_req), .irq_req(irq_req)
    );

    assign dbg_port = trace_busy ? trace_nib : {status[2:0], 1'b0};

    AST_RD_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd && !reg_wr && (status == 4'b0010 || status == 4'b0110)) |=> status == 4'b0000); // R6
endmodule

// File: tb/dbg_trig_unit_tb.sv
module dbg_trig_unit_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 0, reg_rd = 0;
    logic [2:0]  reg_sel = 0;
    logic [31:0] reg_wdata = 0, reg_rdata;
    logic        fetch_vld = 0, bus_vld = 0, sample_pt = 0;
    logic [31:0] fetch_pc = 0, bus_addr = 0, bus_data = 0;
    logic        trace_busy = 0;
    logic [3:0]  trace_nib = 0, dbg_port;
    logic        halt_req, irq_req;

    int errs = 0, checks = 0, tick = 0;
    bit done = 0, quiet_port = 0;

    logic [7:0]  m_ctl = 0;
    logic [31:0] m_pcv = 0, m_pcm = 0, m_lo = 0, m_hi = 0, m_dv = 0, m_dm = 0;
    logic [3:0]  m_st = 0;
    bit          m_pend = 0;

    always #4 clk = ~clk;

    dbg_trig_unit u_dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_sel(reg_sel), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .fetch_vld(fetch_vld), .fetch_pc(fetch_pc), .bus_vld(bus_vld),
        .bus_addr(bus_addr), .bus_data(bus_data), .sample_pt(sample_pt),
        .trace_busy(trace_busy), .trace_nib(trace_nib), .dbg_port(dbg_port),
        .halt_req(halt_req), .irq_req(irq_req)
    );

    task automatic chk(string rq, string nm, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s %s actual=%h expected=%h", rq, nm, act, exp);
        end
    endtask

    // one clock of the behavioural reference; inputs are already set
    task automatic cyc();
        bit pch, ah, dh, l1f, l1b, l2f, l2b, l2any, wctl, fire, prec, resp;
        logic [31:0] exp_rd;
        tick++;
        trace_busy = quiet_port ? 1'b0 : (tick % 3 == 0);
        trace_nib  = 4'(tick * 7);
        #1;
        pch   = fetch_vld && (((fetch_pc ^ m_pcv) & m_pcm) == 0);   // R1
        ah    = bus_vld && bus_addr >= m_lo && bus_addr <= m_hi;    // R2
        dh    = bus_vld && (((bus_data ^ m_dv) & m_dm) == 0);       // R3
        l1f   = m_ctl[2] && pch;  l1b = (m_ctl[3] && ah) || (m_ctl[4] && dh);
        l2f   = m_ctl[5] && pch;  l2b = (m_ctl[6] && ah) || (m_ctl[7] && dh);
        l2any = m_ctl[7:5] != 0;
        wctl  = reg_wr && reg_sel == 0;
        fire = 0; prec = 0;
        if (!wctl && m_st == 4'b0001 && !l2any && (l1f || l1b)) begin fire = 1; prec = l1f; end
        if (!wctl && m_st == 4'b0101 && (l2f || l2b))           begin fire = 1; prec = l2f; end
        resp = (fire && prec) || (m_pend && sample_pt);
        chk("R8 R9 R10", "halt_req", halt_req, resp && m_ctl[1:0] == 2'b01);
        chk("R8 R9 R10", "irq_req",  irq_req,  resp && m_ctl[1:0] == 2'b10);
        chk("R11", "dbg_port", dbg_port, trace_busy ? trace_nib : {m_st[2:0], 1'b0});
        case (reg_sel)
            0: exp_rd = {24'h0, m_ctl};
            1: exp_rd = m_pcv;  2: exp_rd = m_pcm;
            3: exp_rd = m_lo;   4: exp_rd = m_hi;
            5: exp_rd = m_dv;   6: exp_rd = m_dm;
            default: exp_rd = {28'h0, m_st};
        endcase
        chk("R6 R12", "reg_rdata", reg_rdata, exp_rd);
        @(posedge clk);
        if (wctl) begin
            m_ctl  = reg_wdata[7:0];
            m_st   = (reg_wdata[4:2] != 0) ? 4'b0001 : 4'b0000;   // R7
            m_pend = 0;
        end else begin
            if (fire && !prec)   m_pend = 1;
            else if (sample_pt)  m_pend = 0;
            if (m_st == 4'b0001 && (l1f || l1b)) m_st = l2any ? 4'b0101 : 4'b0010;
            else if (m_st == 4'b0101 && (l2f || l2b)) m_st = 4'b0110;
            else if (reg_rd && reg_sel == 7 && (m_st == 4'b0010 || m_st == 4'b0110)) m_st = 4'b0000;
            if (reg_wr) case (reg_sel)
                1: m_pcv = reg_wdata;  2: m_pcm = reg_wdata;
                3: m_lo  = reg_wdata;  4: m_hi  = reg_wdata;
                5: m_dv  = reg_wdata;  6: m_dm  = reg_wdata;
                default: ;
            endcase
        end
        @(negedge clk);
        reg_wr = 0; reg_rd = 0; fetch_vld = 0; bus_vld = 0; sample_pt = 0;
    endtask

    task automatic wr(input logic [2:0] s, input logic [31:0] d);
        reg_wr = 1; reg_sel = s; reg_wdata = d; cyc();
    endtask
    task automatic rd(input logic [2:0] s);
        reg_rd = 1; reg_sel = s; cyc();
    endtask
    task automatic fetch(input logic [31:0] a);
        fetch_vld = 1; fetch_pc = a; cyc();
    endtask
    task automatic bus(input logic [31:0] a, input logic [31:0] d);
        bus_vld = 1; bus_addr = a; bus_data = d; cyc();
    endtask
    task automatic samp();
        sample_pt = 1; cyc();
    endtask
    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc();
    endtask
    // direct look at the status on the port with trace held off
    task automatic peek(string rq, input logic [3:0] code);
        quiet_port = 1; reg_sel = 7; #0;
        cyc();
        quiet_port = 0;
        chk(rq, "status code", {28'h0, m_st}, {28'h0, code});
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R12: reset state
        for (int s = 0; s < 8; s++) begin reg_sel = 3'(s); cyc(); end
        chk("R12", "halt after reset", halt_req, 0);
        peek("R12", 4'b0000);

        // R1 + R4 + R9: single-level fetch trigger, halt mode
        wr(1, 32'h0000_1000); wr(2, 32'hFFFF_FFF0);
        wr(0, 32'h05);
        peek("R7", 4'b0001);
        fetch(32'h0000_2000);
        fetch(32'h0000_100C);                 // masked low bits ignored, halt same cycle
        peek("R4", 4'b0010);
        rd(7);                                // R6 clear
        peek("R6", 4'b0000);

        // R2 + R10: range trigger, interrupt mode, pending until sample
        wr(3, 32'h40); wr(4, 32'h80);
        wr(0, 32'h0A);
        samp();                               // nothing pending
        bus(32'h3F, 0);
        bus(32'h81, 0);
        bus(32'h80, 0);                       // upper bound included
        idle(2);
        samp();                               // irq pulse here
        samp();                               // no second pulse
        peek("R4", 4'b0010);
        rd(7);
        wr(0, 32'h0A);
        bus(32'h40, 0);                       // lower bound included
        samp();
        rd(7);

        // R3 + R5: two-level, data then fetch
        wr(5, 32'h0000_AB00); wr(6, 32'h0000_FF00);
        wr(0, 32'h31);
        fetch(32'h0000_1004);                 // level-2 source before level 1: ignored
        rd(7);                                // read in 0001 keeps status
        peek("R5", 4'b0001);
        bus(32'h0, 32'h0000_AC00);            // data miss
        bus(32'h0, 32'h0000_AB77);            // data hit under mask
        peek("R5", 4'b0101);
        rd(7);
        peek("R6", 4'b0101);
        fetch(32'h0000_1008);                 // precise level-2 halt
        peek("R5", 4'b0110);
        rd(7);
        peek("R6", 4'b0000);

        // R8: quiet response modes still advance status
        wr(0, 32'h04);
        fetch(32'h0000_1001);
        peek("R8", 4'b0010);
        wr(0, 32'h07);
        fetch(32'h0000_1002);
        peek("R8", 4'b0010);

        // R7: write discards pending and clears a fired status
        wr(0, 32'h0A);
        bus(32'h50, 0);
        wr(0, 32'h0A);
        samp();                               // no pulse: flushed
        peek("R7", 4'b0001);
        wr(0, 32'h00);
        peek("R7", 4'b0000);
        bus(32'h50, 0);
        samp();

        // R10: two-level with bus level 2, pending then sample
        wr(0, 32'hC6);                        // L1 fetch, L2 range+data, irq
        fetch(32'h0000_1000);
        bus(32'h60, 32'h0000_AB00);
        fetch(32'h0000_1000);
        samp();
        peek("R10", 4'b0110);
        idle(3);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errs++; checks++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end
endmodule